// File: doc/BRIEF.md
# AC-link Codec Status Slot Generator

This block is the codec-side source of the status return on the serial input line of an AC-link frame. A frame is 256 bit times long. It opens with a 16-bit tag slot (slot 0) and is followed by twelve 20-bit slots. The block fills slot 0, slot 1 and slot 2, and drives every audio slot after them as zero. Slot 1 carries two things: the echo of a register index whose read data is being returned, and a set of per-DAC-slot data request flags. Slot 2 carries the 16-bit read data.

Register reads arrive on a valid/ready stream. `rd_ready` is held high at all times, so the stream never applies back-pressure. A transfer takes place on every rising `bit_clk` edge where `rd_valid` is high. A newer transfer replaces an older one that has not yet been returned. The frame after the transfer returns the read. The data request flags are recomputed for every frame from the variable-rate enable and from the per-slot power, rate and sample-need inputs. They do not depend on whether a read is being returned. The controller sets the frame start by raising `sync`. All output changes on the rising edge of `bit_clk`.

Top module: `ac_status_tx`

## Requirements
- R1: After reset `status_bit` is 0 until the first frame start, and `rd_ready` is 1 at all times.
- R2: A frame starts on a rising `bit_clk` edge where `sync` is 1 and was 0 at the previous edge. On that edge `status_bit` shows the first frame bit. Each following edge shows the next bit, MSB first, in this order: 16 bits of slot 0, 20 bits of slot 1, 20 bits of slot 2. The remaining 200 bits of the frame are 0, and the line stays 0 after them until the next frame start.
- R3: Slot 0 bit 15 equals `codec_ready`. Bit 14 is the slot 1 tag. Bit 13 is the slot 2 tag. Bits 12:0 are 0.
- R4: The slot 1 and slot 2 tags are both 1 in a frame that returns a read and both 0 in every other frame.
- R5: Slot 1 bit 19 is 0. Bits 18:12 are the returned register index, or 0 when untagged. Bits 11:2 are the request flags: bit 11 is for output slot 3 and bit 2 is for output slot 12. Bits 1:0 are 0.
- R6: The flag for output slot 3+k is 1 exactly when `vra_en` is 1, `dac_pwr_rdy[k]` is 1, `dac_need[k]` is 0 and `dac_rate48[k]` is 0. It is therefore 0 whenever variable rate is off or that DAC is powered down.
- R7: The request flags keep their computed values in both tagged and untagged frames.
- R8: Slot 2 bits 19:4 are the returned read data and bits 3:0 are 0. All 20 bits are 0 in an untagged frame.
- R9: A read transferred on an edge after a frame start is returned in the next frame, with its index and data echoed unchanged. A read transferred on the frame-start edge itself is returned in the frame after that one. A later transfer before the return replaces an earlier one. Once a read is returned it is not repeated.
- R10: `codec_ready`, `vra_en` and the per-slot inputs are sampled only at the frame-start edge. Changes to them during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Frame sync; a rising level starts a frame |
| codec_ready | input | 1 | Codec ready flag, sent in slot 0 bit 15 |
| vra_en | input | 1 | Variable-rate mode enable |
| dac_pwr_rdy | input | 10 | Bit k: DAC for output slot 3+k is powered and ready |
| dac_need | input | 10 | Bit k: DAC for output slot 3+k needs a sample next frame |
| dac_rate48 | input | 10 | Bit k: DAC for output slot 3+k runs at 48 kHz |
| rd_valid | input | 1 | Register read return is offered |
| rd_ready | output | 1 | Always 1; a read offer is never stalled |
| rd_index | input | 7 | Control register index of the read |
| rd_data | input | 16 | Read data for that index |
| status_bit | output | 1 | Serial status line, one frame bit per clock |

## Verification
The assertions assume that `sync` rises at most once every 256 clocks and that `rd_valid` is a clean level sampled at the clock edge. They also assume that the per-slot inputs can change at any time, because sampling is confined to the frame-start edge. The stimulus drives every input on the falling edge and raises `sync` only after a full 256-bit frame and a short idle gap. It changes the slot and ready inputs in the middle of each frame and restores them before the next start. It places read offers on the start edge, early in the frame and late in the frame, so that each capture rule is exercised at its boundary.

// File: rtl/acst_pkg.sv
package acst_pkg;
  localparam int IDX_W      = 7;
  localparam int DAT_W      = 16;
  localparam int N_REQ      = 10;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int FRAME_BITS = 256;
  localparam int LOAD_W     = TAG_W + 2 * SLOT_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [DAT_W-1:0] dat;
  } rd_rec_t;
endpackage

// File: rtl/acst_slotreq.sv
module acst_slotreq #(
  parameter int N = acst_pkg::N_REQ
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vra,
  input  logic [N-1:0] pwr,
  input  logic [N-1:0] need,
  input  logic [N-1:0] r48,
  output logic [N-1:0] field
);
  // field MSB belongs to the lowest output slot
  for (genvar k = 0; k < N; k++) begin : g_slot
    assign field[N-1-k] = vra & pwr[k] & ~need[k] & ~r48[k];

    a_r6_pwr_down: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr[k] |-> !field[N-1-k]);
  end

  a_r6_vra_off: assert property (@(posedge clk) disable iff (!rst_n)
    !vra |-> (field == '0));
endmodule

// File: rtl/acst_rd_hold.sv
module acst_rd_hold
  import acst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [IDX_W-1:0] rd_index,
  input  logic [DAT_W-1:0] rd_data,
  output logic             ret_valid,
  output rd_rec_t          ret_rec
);
  assign rd_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_valid <= 1'b0;
      ret_rec   <= '0;
    end else if (rd_valid) begin
      ret_valid   <= 1'b1;
      ret_rec.idx <= rd_index;
      ret_rec.dat <= rd_data;
    end else if (start) begin
      ret_valid <= 1'b0;
    end
  end

  a_r1_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready);
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> ret_valid && ret_rec.idx == $past(rd_index) && ret_rec.dat == $past(rd_data));
  a_r9_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rd_valid) |=> !ret_valid);
endmodule

// File: rtl/acst_frame_ser.sv
module acst_frame_ser
  import acst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             ready,
  input  logic             tag,
  input  rd_rec_t          rec,
  input  logic [N_REQ-1:0] field,
  output logic             start,
  output logic             sbit
);
  localparam int PAD1 = SLOT_W - 1 - IDX_W - N_REQ;
  localparam int PAD2 = SLOT_W - DAT_W;

  logic              sync_d;
  logic [CNT_W-1:0]  cnt;
  logic [LOAD_W-1:0] shreg;
  logic [TAG_W-1:0]  slot0;
  logic [SLOT_W-1:0] slot1, slot2;
  logic [LOAD_W-1:0] word;

  assign start = sync & ~sync_d;

  always_comb begin
    slot0 = '0;
    slot0[TAG_W-1] = ready;
    slot0[TAG_W-2] = tag;
    slot0[TAG_W-3] = tag;
    slot1 = {1'b0, (tag ? rec.idx : {IDX_W{1'b0}}), field, {PAD1{1'b0}}};
    slot2 = tag ? {rec.dat, {PAD2{1'b0}}} : '0;
    word  = {slot0, slot1, slot2};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_d <= 1'b0;
      cnt    <= CNT_W'(FRAME_BITS);
      shreg  <= '0;
      sbit   <= 1'b0;
    end else begin
      sync_d <= sync;
      if (start) begin
        sbit  <= word[LOAD_W-1];
        shreg <= {word[LOAD_W-2:0], 1'b0};
        cnt   <= CNT_W'(1);
      end else if (cnt < CNT_W'(FRAME_BITS)) begin
        sbit  <= shreg[LOAD_W-1];
        shreg <= {shreg[LOAD_W-2:0], 1'b0};
        cnt   <= cnt + CNT_W'(1);
      end else begin
        sbit  <= 1'b0;
      end
    end
  end

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == CNT_W'(1));
  a_r2_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CNT_W'(LOAD_W)) |-> !sbit);
  a_r3_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> sbit == $past(ready));
endmodule

// File: rtl/ac_status_tx.sv
module ac_status_tx
  import acst_pkg::*;
(
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             codec_ready,
  input  logic             vra_en,
  input  logic [N_REQ-1:0] dac_pwr_rdy,
  input  logic [N_REQ-1:0] dac_need,
  input  logic [N_REQ-1:0] dac_rate48,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [IDX_W-1:0] rd_index,
  input  logic [DAT_W-1:0] rd_data,
  output logic             status_bit
);
  logic             start;
  logic             ret_valid;
  rd_rec_t          ret_rec;
  logic [N_REQ-1:0] req_field;

  acst_slotreq #(.N(N_REQ)) u_req (
    .clk(bit_clk), .rst_n(rst_n), .vra(vra_en), .pwr(dac_pwr_rdy),
    .need(dac_need), .r48(dac_rate48), .field(req_field)
  );

  acst_rd_hold u_hold (
    .clk(bit_clk), .rst_n(rst_n), .start(start), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_index(rd_index), .rd_data(rd_data),
    .ret_valid(ret_valid), .ret_rec(ret_rec)
  );

  acst_frame_ser u_ser (
    .clk(bit_clk), .rst_n(rst_n), .sync(sync), .ready(codec_ready),
    .tag(ret_valid), .rec(ret_rec), .field(req_field),
    .start(start), .sbit(status_bit)
  );
endmodule

// File: tb/ac_status_tx_test.sv
`timescale 1ns/1ps
module ac_status_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        codec_ready = 1'b0;
  logic        vra_en = 1'b0;
  logic [9:0]  dac_pwr_rdy = '0, dac_need = '0, dac_rate48 = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [6:0]  rd_index = '0;
  logic [15:0] rd_data = '0;
  logic        status_bit;

  int total = 0, bad = 0;
  bit done = 0;

  // bench-side model of the pending read
  logic        m_v = 1'b0;
  logic [6:0]  m_i = '0;
  logic [15:0] m_d = '0;

  // per-frame read offers
  logic        st_en, a_en, b_en;
  logic [6:0]  st_i, a_i, b_i;
  logic [15:0] st_d, a_d, b_d;

  always #2.5 clk = ~clk;

  ac_status_tx uut (
    .bit_clk(clk), .rst_n(rst_n), .sync(sync), .codec_ready(codec_ready),
    .vra_en(vra_en), .dac_pwr_rdy(dac_pwr_rdy), .dac_need(dac_need),
    .dac_rate48(dac_rate48), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_index(rd_index), .rd_data(rd_data), .status_bit(status_bit)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_frame();
    logic [15:0]  e0, g0;
    logic [19:0]  e1, e2, g1, g2;
    logic [9:0]   ef;
    logic [255:0] got;
    logic         t;
    logic         s_rdy, s_vra;
    logic [9:0]   s_p, s_n, s_r;
    int           tailbad;
    t = m_v;
    for (int k = 0; k < 10; k++)
      ef[9-k] = vra_en & dac_pwr_rdy[k] & ~dac_need[k] & ~dac_rate48[k];
    e0 = {codec_ready, t, t, 13'd0};
    e1 = {1'b0, (t ? m_i : 7'd0), ef, 2'b00};
    e2 = t ? {m_d, 4'd0} : 20'd0;
    s_rdy = codec_ready; s_vra = vra_en; s_p = dac_pwr_rdy; s_n = dac_need; s_r = dac_rate48;
    m_v = 1'b0;
    @(negedge clk);
    sync = 1'b1;
    rd_valid = st_en; rd_index = st_i; rd_data = st_d;
    if (st_en) begin m_v = 1'b1; m_i = st_i; m_d = st_d; end
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      got[255-i] = status_bit;
      sync = 1'b0;
      rd_valid = 1'b0;
      if (a_en && i == 10) begin rd_valid = 1'b1; rd_index = a_i; rd_data = a_d; end
      if (b_en && i == 100) begin rd_valid = 1'b1; rd_index = b_i; rd_data = b_d; end
      if (i == 20) begin // R10: disturb sampled inputs mid-frame
        codec_ready = ~s_rdy; vra_en = ~s_vra; dac_pwr_rdy = ~s_p; dac_need = ~s_n; dac_rate48 = ~s_r;
      end
      if (i == 250) begin
        codec_ready = s_rdy; vra_en = s_vra; dac_pwr_rdy = s_p; dac_need = s_n; dac_rate48 = s_r;
      end
    end
    if (a_en) begin m_v = 1'b1; m_i = a_i; m_d = a_d; end
    if (b_en) begin m_v = 1'b1; m_i = b_i; m_d = b_d; end
    tailbad = 0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      if (status_bit !== 1'b0) tailbad++;
    end
    g0 = got[255:240]; g1 = got[239:220]; g2 = got[219:200];
    chk(g0 === e0, "R3 R4 R10 slot0", 64'(g0), 64'(e0));
    chk(g1[11:2] === ef, "R6 R7 R10 request flags", 64'(g1[11:2]), 64'(ef));
    chk(g1 === e1, "R5 R9 slot1", 64'(g1), 64'(e1));
    chk(g2 === e2, "R8 R9 slot2", 64'(g2), 64'(e2));
    chk(got[199:0] === '0 && tailbad == 0, "R2 zero tail", 64'(tailbad), 64'd0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(status_bit === 1'b0, "R1 idle after reset", 64'(status_bit), 64'd0);
    chk(rd_ready === 1'b1, "R1 ready high", 64'(rd_ready), 64'd1);
    for (int f = 0; f < 20; f++) begin
      vra_en = (f % 16) >= 8;
      codec_ready = f[0];
      for (int k = 0; k < 10; k++) begin
        int c;
        c = (k + f) % 8;
        dac_pwr_rdy[k] = c[0];
        dac_need[k]    = c[1];
        dac_rate48[k]  = c[2];
      end
      st_en = 0; a_en = 0; b_en = 0;
      st_i = 7'h00; a_i = 7'h00; b_i = 7'h00;
      st_d = 16'h0; a_d = 16'h0; b_d = 16'h0;
      // R9: single offer in frame 3, returned in frame 4 only (R4 in frame 5)
      if (f == 3) begin a_en = 1; a_i = 7'h7F; a_d = 16'hFFFF; end
      // R9: two offers in frame 6, the later one wins in frame 7
      if (f == 6) begin a_en = 1; a_i = 7'h2A; a_d = 16'h1234; b_en = 1; b_i = 7'h55; b_d = 16'hBEEF; end
      // R9: offer on the start edge of frame 9 is returned in frame 10, not 9
      if (f == 9) begin st_en = 1; st_i = 7'h01; st_d = 16'h8001; end
      // R7: tagged frames with variable rate on
      if (f == 11) begin b_en = 1; b_i = 7'h40; b_d = 16'h0F0F; end
      if (f == 12) begin st_en = 1; st_i = 7'h13; st_d = 16'hC3A5; a_en = 1; a_i = 7'h66; a_d = 16'h5A5A; end
      do_frame();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule